// File: doc/BRIEF.md
# Accumulator-Fed Eight-Function ALU

This block is a narrow arithmetic/logic unit for a tiny processor that keeps one working value. The first operand arrives on a data input, normally a word just read from memory. The second operand is never read from a register file. It is always the result the unit produced last, held in an internal result register. On each cycle with the strobe high, the unit applies one of eight functions, chosen by a 3-bit opcode, to the input word and the held value. The new result drives the output for write-back and also becomes the next second operand.

The opcode is a reduced form of a wider function select. The mode bit and the top select bit are tied to 1, and the opcode supplies the three low select bits. Two codes would otherwise select logic functions that are of no use: the one that yields the complement of the input ORed with the held value, and the one that yields all ones. The decoder moves these two codes onto the arithmetic patterns for addition and for decrement. Loading a value takes one pass-A operation. Complementing the held value takes an OR-NOT with an input of zero. A carry/borrow flag and a zero flag are registered next to the result.

Top module: `acc_alu8`

## Requirements
- R1: Opcode 000 stores (A + B) mod 16 as the result, where B is the held result. The carry flag is 1 exactly when A + B exceeds 15.
- R2: Opcode 100 stores (A - 1) mod 16. The carry flag is 1 exactly when A is 0, which is the borrow case.
- R3: Opcodes 001, 011, 101 and 110 store A XNOR B, A AND B, A OR (NOT B) and A OR B respectively, each bit by bit over 4 bits.
- R4: Opcode 010 stores B, so the held result is unchanged.
- R5: Opcode 111 stores A, so the input word becomes the next B.
- R6: A strobed result is visible on the output one clock after the strobe edge, and it is the B operand of the next strobed operation.
- R7: After a strobed operation, the zero flag is 1 exactly when the new 4-bit result is 0.
- R8: The opcodes other than 000 and 100 clear the carry flag.
- R9: When the strobe is low, the result and both flags keep their values, whatever the opcode and the A input are.
- R10: A synchronous reset, active high, clears the result, the carry flag and the zero flag to 0 on the next edge.
- R11: The sequence pass-A x, then AND y, then OR-NOT with A = 0 leaves NOT (x AND y) as the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Strobe: perform one operation this cycle |
| op_i | input | 3 | Function code |
| a_i | input | 4 | A operand (memory data) |
| res_o | output | 4 | Registered result, which is also the next B operand |
| carry_o | output | 1 | Carry out of an add, or borrow of a decrement |
| zero_o | output | 1 | Result equals zero |

## Verification
The assertions take the inputs to be known, non-X values on every clock edge where reset is low. They also take it that reset is held for at least one edge before operations start, so that the result register has a defined value when it is first used as B. The stimulus drives every input at the falling edge, holds reset for several edges at the start and once in the middle of the run, and draws the opcode, the data word and the strobe from a seeded generator that only produces 0/1 values. Directed sequences cover the carry and borrow boundaries, zero results, idle cycles with changing inputs, and the NAND composition.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  // Function codes, exactly as seen on op_i
  typedef enum logic [2:0] {
    FN_ADD   = 3'b000,
    FN_XNOR  = 3'b001,
    FN_PASSB = 3'b010,
    FN_AND   = 3'b011,
    FN_DEC   = 3'b100,
    FN_ORN   = 3'b101,
    FN_OR    = 3'b110,
    FN_PASSA = 3'b111
  } fn_e;

  // Expanded control word: a mode bit (1 = logic, 0 = arithmetic)
  // and the four-bit function select
  typedef struct packed {
    logic       logic_mode;
    logic [3:0] sel;
  } ctl_t;

  localparam logic [3:0] SEL_ARITH_ADD = 4'b1001;
  localparam logic [3:0] SEL_ARITH_DEC = 4'b1111;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [2:0] op_i,
  output ctl_t       ctl_o,
  output logic       is_arith_o
);

  // The mode and top select bits are tied high. The two codes whose
  // logic meaning is not wanted are moved onto arithmetic patterns.
  always_comb begin
    ctl_o.logic_mode = 1'b1;
    ctl_o.sel        = {1'b1, op_i};
    unique case (fn_e'(op_i))
      FN_ADD: begin
        ctl_o.logic_mode = 1'b0;
        ctl_o.sel        = SEL_ARITH_ADD;
      end
      FN_DEC: begin
        ctl_o.logic_mode = 1'b0;
        ctl_o.sel        = SEL_ARITH_DEC;
      end
      default: ;
    endcase
  end

  assign is_arith_o = ~ctl_o.logic_mode;

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  ctl_t         ctl_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  // Logic half of the select space, upper select bit set
  function automatic logic [W-1:0] logic_fn(input logic [3:0] sel,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    logic [W-1:0] r;
    unique case (sel[2:0])
      3'b000:  r = ~a | b;
      3'b001:  r = ~(a ^ b);
      3'b010:  r = b;
      3'b011:  r = a & b;
      3'b100:  r = ONES;
      3'b101:  r = a | ~b;
      3'b110:  r = a | b;
      default: r = a;
    endcase
    return r;
  endfunction

  // Arithmetic patterns in use; the top bit of the result is carry/borrow
  function automatic logic [W:0] arith_fn(input logic [3:0] sel,
                                          input logic [W-1:0] a,
                                          input logic [W-1:0] b);
    logic [W:0] r;
    if (sel == SEL_ARITH_ADD)
      r = {1'b0, a} + {1'b0, b};
    else if (sel == SEL_ARITH_DEC)
      r = {1'b0, a} - {{W{1'b0}}, 1'b1};
    else
      r = {1'b0, a};
    return r;
  endfunction

  logic [W:0] arith_w;

  always_comb begin
    arith_w = arith_fn(ctl_i.sel, a_i, b_i);
    if (ctl_i.logic_mode) begin
      res_o   = logic_fn(ctl_i.sel, a_i, b_i);
      carry_o = 1'b0;
    end else begin
      res_o   = arith_w[W-1:0];
      carry_o = arith_w[W];
    end
  end

endmodule

// File: rtl/acc_alu_state.sv
module acc_alu_state #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] res_i,
  input  logic         carry_i,
  output logic [W-1:0] res_q,
  output logic         carry_q,
  output logic         zero_q
);

  logic zero_n;
  assign zero_n = (res_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (load_i) begin
      res_q   <= res_i;
      carry_q <= carry_i;
      zero_q  <= zero_n;
    end
  end

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         zero_o
);

  ctl_t         ctl_w;
  logic         is_arith_w;
  logic [W-1:0] res_n;
  logic         carry_n;

  // Named events for the checker
  logic ev_load;
  logic ev_wrap;
  assign ev_load = valid_i & ~rst;
  assign ev_wrap = ev_load & is_arith_w & carry_n;

  acc_alu_decode u_dec (
    .op_i      (op_i),
    .ctl_o     (ctl_w),
    .is_arith_o(is_arith_w)
  );

  acc_alu_core #(.W(W)) u_core (
    .ctl_i  (ctl_w),
    .a_i    (a_i),
    .b_i    (res_o),
    .res_o  (res_n),
    .carry_o(carry_n)
  );

  acc_alu_state #(.W(W)) u_state (
    .clk    (clk),
    .rst    (rst),
    .load_i (valid_i),
    .res_i  (res_n),
    .carry_i(carry_n),
    .res_q  (res_o),
    .carry_q(carry_o),
    .zero_q (zero_o)
  );

endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] res_o,
  input logic         carry_o,
  input logic         zero_o,
  input logic         ev_load,
  input logic         ev_wrap
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !carry_o && !zero_o)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(res_o) && $stable(carry_o) && $stable(zero_o))); // R9

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    ev_load |=> (zero_o == (res_o == '0))); // R7

  AST_PASS_A: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'b111) |=> (res_o == $past(a_i))); // R5

  AST_PASS_B: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'b010) |=> $stable(res_o)); // R4

  AST_DEC_VALUE: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i == 3'b100) |=>
      (res_o == W'($past(a_i) - W'(1)) && carry_o == ($past(a_i) == '0))); // R2

  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (rst)
    ev_wrap |=> carry_o); // R1

  AST_NO_CARRY_LOGIC: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op_i[1:0] != 2'b00) |=> !carry_o); // R8

endmodule

bind acc_alu8 acc_alu8_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .valid_i(valid_i),
  .op_i   (op_i),
  .a_i    (a_i),
  .res_o  (res_o),
  .carry_o(carry_o),
  .zero_o (zero_o),
  .ev_load(ev_load),
  .ev_wrap(ev_wrap)
);

// File: tb/tb_acc_alu8.sv
module tb_acc_alu8;

  logic       clk = 1'b0;
  logic       rst;
  logic       valid_i;
  logic [2:0] op_i;
  logic [3:0] a_i;
  logic [3:0] res_o;
  logic       carry_o;
  logic       zero_o;

  int n_chk  = 0;
  int n_fail = 0;

  // Bench model of the held state
  int m_res   = 0;
  int m_carry = 0;
  int m_zero  = 0;

  always #4 clk = ~clk;

  acc_alu8 dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .a_i(a_i),
    .res_o(res_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1";
      4: return "R2";
      2: return "R4";
      7: return "R5";
      default: return "R3";
    endcase
  endfunction

  // Expected {carry, result} from the requirement text, using integers
  function automatic int expect_val(input int op, input int a, input int b);
    int s;
    case (op)
      0: begin s = a + b; return (s > 15) ? (16 + s - 16) : s; end
      4: return (a == 0) ? 16 + 15 : a - 1;
      1: return 15 - (a ^ b);
      2: return b;
      3: return a & b;
      5: return a | (15 - b);
      6: return a | b;
      default: return a;
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " result"}, int'(res_o), m_res);
    check({tag, " carry"}, int'(carry_o), m_carry);
    check({tag, " zero (R7)"}, int'(zero_o), m_zero);
  endtask

  // Drive at the falling edge, let the rising edge capture, check at the next falling edge
  task automatic step(input bit v, input int op, input int a);
    int e;
    string t;
    @(negedge clk);
    valid_i = v;
    op_i    = 3'(op);
    a_i     = 4'(a);
    if (v) begin
      e       = expect_val(op, a, m_res);
      m_carry = (e >= 16) ? 1 : 0;
      m_res   = e % 16;
      m_zero  = (m_res == 0) ? 1 : 0;
      t = tag_of(op);
      if (op != 0 && op != 4) t = {t, "/R8"};
    end else begin
      t = "R9 idle";
    end
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    check_all({t, " R6"});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    valid_i = 1'b1;
    op_i = 3'b111;
    a_i = 4'hA;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    valid_i = 1'b0;
    m_res = 0; m_carry = 0; m_zero = 0;
    check_all("R10 reset");
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1'b1; valid_i = 1'b0; op_i = '0; a_i = '0;
    do_reset();

    // R1: add with overflow to exactly zero, then a plain add
    step(1, 7, 9);
    step(1, 0, 7);     // 9+7 = 16 -> 0, carry, zero
    step(1, 0, 3);     // 0+3
    step(1, 0, 15);    // 3+15 = 18 -> 2, carry
    // R2: decrement boundaries
    step(1, 4, 0);     // borrow -> 15
    step(1, 4, 1);     // -> 0, zero
    step(1, 4, 15);
    // R3 / R4 / R5 patterns
    step(1, 7, 4'b1100);
    step(1, 1, 4'b1010);
    step(1, 3, 4'b0110);
    step(1, 5, 4'b0011);
    step(1, 6, 4'b1000);
    step(1, 2, 4'b0000);
    // R9: idle cycles with moving inputs
    for (int i = 0; i < 8; i++) step(0, i, 15 - i);
    // R11: NAND composition x=1011, y=0110 -> ~0010 = 1101
    step(1, 7, 4'b1011);
    step(1, 3, 4'b0110);
    step(1, 5, 0);
    check("R11 nand", int'(res_o), 13);
    // R8: carry set by add, then cleared by a logic op
    step(1, 7, 15);
    step(1, 0, 1);
    step(1, 6, 0);
    check("R8 carry cleared", int'(carry_o), 0);

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 16));
      if (i == 300) do_reset();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule